// File: doc/BRIEF.md
# UART Transmit Pacing and Line-Direction Control

This block sits between a UART transmit queue and the serializer that shifts characters out. It decides when the serializer may start a new character, and it drives the active-low request-to-send line. That line can serve as the driver enable of a half-duplex differential transceiver.

Two optional behaviours can be enabled.

- **Clear-to-send pacing.** The block can honour a remote clear-to-send line. When the far end raises that line, new character starts stop at the next character boundary. A character that is already being shifted out always finishes.
- **Line-direction mode.** The request-to-send output is pulled low when the first character is granted. It is released only after a programmable number of bit times (0 to 15) following the final stop bit. This gives the far end time to see the line turn around. If more data is queued, the line simply stays driven.

When direction mode is off, the request-to-send output follows an ordinary modem-control bit.

Top module: `txflow_dirctl`

## Requirements
- R1: While reset is asserted and directly after it, `start_grant` is 0 and `rts_n` is 1 (released) in direction mode. The turnaround delay register resets to 0.
- R2: `start_grant` pulses high for one cycle in any cycle where the queue is not empty, the serializer is idle and no clear-to-send hold applies. It is never high in two consecutive cycles.
- R3: `start_grant` stays 0 while `ser_busy` is 1, so a character in progress is never interrupted or doubled.
- R4: A clear-to-send hold applies only when both `auto_cts_en` and `cts_flow_sel` are 1 and the synchronized `cts_n` is 1. With either enable bit at 0, `cts_n` has no effect on `start_grant`.
- R5: `cts_n` passes through SYNC_STAGES flops before it affects the grant. After `cts_n` falls, a waiting character is granted in the third cycle, counting the cycle of the fall as the first.
- R6: In direction mode (`dir_ctl_en` = 1), `rts_n` goes to 0 in the cycle after a grant. It stays 0 while the character is sent.
- R7: With turnaround delay N > 0, `rts_n` stays 0 after the final `stop_done` pulse until the N-th `bit_tick` that follows it. It returns to 1 in the cycle after that tick.
- R8: With turnaround delay 0, `rts_n` returns to 1 in the cycle after the final `stop_done` pulse.
- R9: If the queue becomes non-empty while the turnaround count is running, the count is cancelled and `rts_n` stays 0. Later ticks do not release it until the following character's `stop_done`.
- R10: `dly_wr` loads `dly_wdata` into the delay register only when `ext_en` is 1. Otherwise the write is ignored and the old delay stays in effect.
- R11: With `dir_ctl_en` = 0, `rts_n` equals the inverse of `mcr_rts`.
- R12: A `stop_done` pulse that arrives while the queue is not empty keeps `rts_n` at 0 in direction mode, so back-to-back characters share one driven period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | Transmit queue holds no character |
| ser_busy | input | 1 | Serializer is shifting a character |
| stop_done | input | 1 | One-cycle pulse at the end of a character's last stop bit |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| cts_n | input | 1 | Active-low clear-to-send from the far end (asynchronous) |
| auto_cts_en | input | 1 | Automatic clear-to-send pacing enable |
| cts_flow_sel | input | 1 | Selects request/clear-to-send as the flow-control pair |
| dir_ctl_en | input | 1 | Line-direction mode enable |
| mcr_rts | input | 1 | Modem-control request-to-send bit (active high) |
| ext_en | input | 1 | Unlocks writes to the turnaround delay |
| dly_wr | input | 1 | Write strobe for the turnaround delay |
| dly_wdata | input | DLY_W | Turnaround delay in bit times |
| start_grant | output | 1 | Permission for the serializer to start one character |
| rts_n | output | 1 | Active-low request-to-send / transceiver driver enable |

## Verification
The bench builds the block with its default parameters: a two-stage clear-to-send synchronizer and a four-bit delay. This makes the exact three-cycle resume latency checkable. It also makes delays 0 and 3 reachable within a few cycles.

Those delays are used to show three things:
- an immediate release after the final stop bit;
- a counted release on the third tick;
- a countdown that is cancelled by a newly queued character and restarted after that character's stop bit.

A delay write with the unlock bit low is shown to be ignored by the immediate release that follows it.

// File: rtl/txflow_dirctl.sv
module txflow_dirctl #(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_empty,
  input  logic             ser_busy,
  input  logic             stop_done,
  input  logic             bit_tick,
  input  logic             cts_n,
  input  logic             auto_cts_en,
  input  logic             cts_flow_sel,
  input  logic             dir_ctl_en,
  input  logic             mcr_rts,
  input  logic             ext_en,
  input  logic             dly_wr,
  input  logic [DLY_W-1:0] dly_wdata,
  output logic             start_grant,
  output logic             rts_n
);

  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  typedef enum logic [1:0] {DIR_IDLE, DIR_SEND, DIR_TURN} dir_t;

  logic [SW-1:0]    cts_sync;
  logic             cts_hold;
  logic             gnt_q;
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] cnt_q;
  dir_t             st_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cts_sync <= '1;
    else        cts_sync <= {cts_sync[SW-2:0], cts_n};

  assign cts_hold    = auto_cts_en & cts_flow_sel & cts_sync[SW-1];
  assign start_grant = ~fifo_empty & ~ser_busy & ~cts_hold & ~gnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= start_grant;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               dly_q <= '0;
    else if (dly_wr && ext_en) dly_q <= dly_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DIR_IDLE;
      cnt_q <= '0;
    end else if (!dir_ctl_en) begin
      st_q  <= DIR_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        DIR_IDLE: if (start_grant) st_q <= DIR_SEND;
        DIR_SEND: if (stop_done && fifo_empty) begin
          if (dly_q == '0) st_q <= DIR_IDLE;
          else begin
            st_q  <= DIR_TURN;
            cnt_q <= dly_q;
          end
        end
        DIR_TURN: if (!fifo_empty) st_q <= DIR_SEND;
          else if (bit_tick) begin
            if (cnt_q == DLY_W'(1)) st_q <= DIR_IDLE;
            cnt_q <= cnt_q - 1'b1;
          end
        default: st_q <= DIR_IDLE;
      endcase
    end
  end

  assign rts_n = dir_ctl_en ? (st_q == DIR_IDLE) : ~mcr_rts;

endmodule

// File: rtl/txflow_dirctl_chk.sv
module txflow_dirctl_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_empty,
  input logic ser_busy,
  input logic stop_done,
  input logic bit_tick,
  input logic cts_n,
  input logic auto_cts_en,
  input logic cts_flow_sel,
  input logic dir_ctl_en,
  input logic start_grant,
  input logic rts_n
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;

  AST_GRANT_IDLE_SER: assert property (@(posedge clk) disable iff (!rst_n)
    start_grant |-> (!ser_busy && !fifo_empty)); // R3

  AST_NO_BACK_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    start_grant |=> !start_grant); // R2

  AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && auto_cts_en && cts_flow_sel && $past(cts_n) && $past(cts_n, 2))
      |-> !start_grant); // R4

  AST_DRIVE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_ctl_en && start_grant) |=> (!rts_n || !dir_ctl_en)); // R6

  AST_HOLD_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && dir_ctl_en && $past(dir_ctl_en) && !$past(rts_n) && !$past(fifo_empty))
      |-> !rts_n); // R9

  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && dir_ctl_en && $past(dir_ctl_en) && $rose(rts_n))
      |-> ($past(stop_done) || $past(bit_tick))); // R7

endmodule

bind txflow_dirctl txflow_dirctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .ser_busy(ser_busy),
  .stop_done(stop_done), .bit_tick(bit_tick), .cts_n(cts_n),
  .auto_cts_en(auto_cts_en), .cts_flow_sel(cts_flow_sel), .dir_ctl_en(dir_ctl_en),
  .start_grant(start_grant), .rts_n(rts_n)
);

// File: tb/txflow_dirctl_bench.sv
module txflow_dirctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_empty = 1'b1, ser_busy = 1'b0, stop_done = 1'b0, bit_tick = 1'b0;
  logic       cts_n = 1'b0, auto_cts_en = 1'b0, cts_flow_sel = 1'b0;
  logic       dir_ctl_en = 1'b1, mcr_rts = 1'b0, ext_en = 1'b0, dly_wr = 1'b0;
  logic [3:0] dly_wdata = '0;
  logic       start_grant, rts_n;

  always #10 clk = ~clk;

  txflow_dirctl u_txflow_dirctl (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .ser_busy(ser_busy),
    .stop_done(stop_done), .bit_tick(bit_tick), .cts_n(cts_n),
    .auto_cts_en(auto_cts_en), .cts_flow_sel(cts_flow_sel), .dir_ctl_en(dir_ctl_en),
    .mcr_rts(mcr_rts), .ext_en(ext_en), .dly_wr(dly_wr), .dly_wdata(dly_wdata),
    .start_grant(start_grant), .rts_n(rts_n)
  );

  typedef struct {
    logic  g;
    logic  r;
    string req;
  } exp_t;

  exp_t queue_q[$];
  event ev_chk;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   ended = 0;

  always @(ev_chk) begin
    while (queue_q.size() > 0) begin
      exp_t e;
      bit   bad;
      e   = queue_q.pop_front();
      bad = 0;
      n_vec++;
      if (start_grant !== e.g) begin
        $display("FAIL %s start_grant actual=%b expected=%b t=%0t", e.req, start_grant, e.g, $time);
        bad = 1;
      end
      if (rts_n !== e.r) begin
        $display("FAIL %s rts_n actual=%b expected=%b t=%0t", e.req, rts_n, e.r, $time);
        bad = 1;
      end
      if (bad) n_bad++;
    end
  end

  task automatic cyc(input logic g, input logic r, input string req);
    exp_t e;
    e.g = g; e.r = r; e.req = req;
    #1;
    queue_q.push_back(e);
    ->ev_chk;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog expired at t=%0t", $time);
    n_bad++;
    finish_run();
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(0, 1, "R1");
    rst_n = 1;               cyc(0, 1, "R1");
    dly_wr = 1; dly_wdata = 4'd5; cyc(0, 1, "R10");
    dly_wr = 0;
    fifo_empty = 0;          cyc(1, 1, "R2");
                             cyc(0, 0, "R2/R6");
    ser_busy = 1;            cyc(0, 0, "R3");
    bit_tick = 1;            cyc(0, 0, "R3");
    bit_tick = 0;            cyc(0, 0, "R3");
    stop_done = 1; ser_busy = 0; cyc(1, 0, "R12");
    stop_done = 0; ser_busy = 1; fifo_empty = 1; cyc(0, 0, "R12");
    bit_tick = 1;            cyc(0, 0, "R12");
    bit_tick = 0; stop_done = 1; ser_busy = 0; cyc(0, 0, "R8");
    stop_done = 0;           cyc(0, 1, "R8/R1");
                             cyc(0, 1, "R10");
    ext_en = 1; dly_wr = 1; dly_wdata = 4'd3; cyc(0, 1, "R10");
    dly_wr = 0; fifo_empty = 0; cyc(1, 1, "R2");
    ser_busy = 1; fifo_empty = 1; cyc(0, 0, "R6");
                             cyc(0, 0, "R6");
    stop_done = 1; ser_busy = 0; cyc(0, 0, "R7");
    stop_done = 0;           cyc(0, 0, "R7");
    bit_tick = 1;            cyc(0, 0, "R7");
    bit_tick = 0;            cyc(0, 0, "R7");
    bit_tick = 1;            cyc(0, 0, "R7");
                             cyc(0, 0, "R7");
    bit_tick = 0;            cyc(0, 1, "R7");
    fifo_empty = 0;          cyc(1, 1, "R2");
    ser_busy = 1; fifo_empty = 1; cyc(0, 0, "R6");
    stop_done = 1; ser_busy = 0; cyc(0, 0, "R9");
    stop_done = 0; bit_tick = 1; cyc(0, 0, "R9");
    bit_tick = 0; fifo_empty = 0; cyc(1, 0, "R9");
    ser_busy = 1; fifo_empty = 1; bit_tick = 1;
    for (int i = 0; i < 4; i++) cyc(0, 0, "R9");
    bit_tick = 0; stop_done = 1; ser_busy = 0; cyc(0, 0, "R9");
    stop_done = 0; bit_tick = 1;
    for (int i = 0; i < 3; i++) cyc(0, 0, "R9");
    bit_tick = 0;            cyc(0, 1, "R9");
    dly_wr = 1; dly_wdata = 4'd0; cyc(0, 1, "R10");
    dly_wr = 0; auto_cts_en = 1; cts_flow_sel = 0; cts_n = 1;
    for (int i = 0; i < 3; i++) cyc(0, 1, "R4");
    fifo_empty = 0;          cyc(1, 1, "R4");
    ser_busy = 1; fifo_empty = 1; cyc(0, 0, "R6");
    stop_done = 1; ser_busy = 0; cyc(0, 0, "R8");
    stop_done = 0;           cyc(0, 1, "R8");
    cts_flow_sel = 1; fifo_empty = 0;
    for (int i = 0; i < 3; i++) cyc(0, 1, "R4");
    cts_n = 0;               cyc(0, 1, "R5");
                             cyc(0, 1, "R5");
                             cyc(1, 1, "R5");
    fifo_empty = 1; ser_busy = 1; cyc(0, 0, "R3");
    cts_n = 1;               cyc(0, 0, "R3");
                             cyc(0, 0, "R3");
    stop_done = 1; ser_busy = 0; cyc(0, 0, "R3");
    stop_done = 0; fifo_empty = 0; cyc(0, 1, "R4");
                             cyc(0, 1, "R4");
    fifo_empty = 1; dir_ctl_en = 0; mcr_rts = 1; cyc(0, 0, "R11");
    mcr_rts = 0;             cyc(0, 1, "R11");
    finish_run();
  end

endmodule